// File: doc/BRIEF.md
# Home-Node Sharing-Chain Directory Controller

This block sits at the home node of a distributed shared-memory machine and keeps the directory for a set of cache lines. Each line is homed here permanently. The home does not hold a sharer bitmap. It keeps a pointer to the first node of a singly-linked chain, and every sharer keeps a pointer to its successor. A null pointer (the all-ones node ID) ends the chain. An empty chain means that the home's own memory holds the current data.

Requests arrive on one valid/ready port. Each request carries a kind, the sender's node ID, a line index and, for an eviction, the leaving node's successor pointer. Every request except an acknowledgement produces exactly one outgoing message on a second valid/ready port:

- a data grant from the home;
- a forwarded read to the chain head;
- an invalidation walk;
- an unlink walk;
- a completion notice for an eviction;
- a retry (NACK).

While an invalidation or unlink walk is in flight, the line is locked. Every request for that line is refused until the final acknowledgement arrives.

Top module: `hsl_home_dir`

## Requirements
- R1: After reset every chain is empty, `msg_valid` is low and `req_ready` is high.
- R2: A read (kind 0) of a line whose chain is empty and unlocked is answered with a grant (message kind 0) to the reader. The grant has `msg_link` equal to the null ID (all ones) and `msg_excl` low. The reader becomes the chain head.
- R3: A read of an unlocked line with a non-empty chain is forwarded (message kind 1) to the current head, with `msg_who` set to the reader. The reader becomes the new head.
- R4: A write (kind 1) to an empty, unlocked line is answered with a grant that has `msg_excl` high. The writer becomes the sole, exclusive head.
- R5: A write to an unlocked line whose chain is non-empty, and is not held exclusively by the writer, sends an invalidation (message kind 2) to the head with `msg_who` set to the writer, and then locks the line.
- R6: Any read, write or eviction of a locked line is answered with a NACK (message kind 4) to the sender, and the line's state does not change.
- R7: An acknowledgement (kind 3) on a line locked by a write unlocks it, produces no message, and leaves the writer as the sole exclusive head.
- R8: An acknowledgement on an unlocked line produces no message and changes nothing.
- R9: An eviction (kind 2) by the chain head is answered with an eviction notice (message kind 5). The head pointer takes the supplied successor. A null successor empties the chain, so the home's copy becomes the live one.
- R10: An eviction by a node that is not the head sends an unlink walk (message kind 3) to the head. The walk carries the leaver in `msg_who` and its successor in `msg_link`. The line stays locked until the acknowledgement, and the head does not change.
- R11: While `msg_valid` is high and `msg_ready` is low, the message holds stable and `req_ready` is low.
- R12: Lines are independent: a lock or a chain on one line does not affect the answers for another line.
- R13: A write from the node that already holds the line exclusively is granted at once with `msg_excl` high, and the line is not locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_kind | input | 2 | 0 read, 1 write, 2 evict, 3 acknowledge |
| req_src | input | NODE_W | Sending node ID |
| req_line | input | LINE_W | Line index |
| req_link | input | NODE_W | Successor of an evicting node |
| msg_valid | output | 1 | Outgoing message present |
| msg_ready | input | 1 | Outgoing message taken |
| msg_kind | output | 3 | 0 grant, 1 forward, 2 invalidate, 3 unlink, 4 NACK, 5 evict done |
| msg_dst | output | NODE_W | Destination node |
| msg_who | output | NODE_W | Original requester or leaving node |
| msg_link | output | NODE_W | Next pointer to install or successor to splice |
| msg_line | output | LINE_W | Line index |
| msg_excl | output | 1 | Grant is exclusive |

## Verification
The bench builds the block with four lines and five nodes. Node IDs then fit in three bits, and the null ID 7 never collides with a real node. With four lines, one line can be locked while its neighbours are still read and written. Chains three nodes deep are grown on one line, so forwarding, head-eviction splicing and non-head unlinking can all be reached. A stalled output port is held for several cycles to expose the back-pressure path.

// File: rtl/hsl_pkg.sv
package hsl_pkg;
   typedef enum logic [1:0] {
      REQ_READ  = 2'd0,
      REQ_WRITE = 2'd1,
      REQ_EVICT = 2'd2,
      REQ_ACK   = 2'd3
   } req_kind_e;

   typedef enum logic [2:0] {
      MSG_GRANT  = 3'd0,
      MSG_FWD    = 3'd1,
      MSG_INVAL  = 3'd2,
      MSG_UNLINK = 3'd3,
      MSG_NACK   = 3'd4,
      MSG_EVOK   = 3'd5
   } msg_kind_e;
endpackage

// File: rtl/hsl_line_slot.sv
module hsl_line_slot #(
   parameter int NODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [NODE_W-1:0] nxt_head,
   input  logic [NODE_W-1:0] nxt_pend,
   input  logic              nxt_excl,
   input  logic              nxt_lock,
   output logic [NODE_W-1:0] head,
   output logic [NODE_W-1:0] pend,
   output logic              excl,
   output logic              lock
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head <= '1;
         pend <= '1;
         excl <= 1'b0;
         lock <= 1'b0;
      end else if (wr_en) begin
         head <= nxt_head;
         pend <= nxt_pend;
         excl <= nxt_excl;
         lock <= nxt_lock;
      end
   end
endmodule

// File: rtl/hsl_decide.sv
module hsl_decide
   import hsl_pkg::*;
#(
   parameter int NODE_W = 3
) (
   input  logic [1:0]        kind,
   input  logic [NODE_W-1:0] src,
   input  logic [NODE_W-1:0] link,
   input  logic [NODE_W-1:0] c_head,
   input  logic [NODE_W-1:0] c_pend,
   input  logic              c_excl,
   input  logic              c_lock,
   output logic              emit,
   output logic              upd,
   output logic [NODE_W-1:0] n_head,
   output logic [NODE_W-1:0] n_pend,
   output logic              n_excl,
   output logic              n_lock,
   output logic [2:0]        o_kind,
   output logic [NODE_W-1:0] o_dst,
   output logic [NODE_W-1:0] o_who,
   output logic [NODE_W-1:0] o_link,
   output logic              o_excl
);
   localparam logic [NODE_W-1:0] NULL_ID = '1;

   logic empty;
   assign empty = (c_head == NULL_ID);

   always_comb begin
      emit   = 1'b1;
      upd    = 1'b0;
      o_kind = MSG_NACK;
      o_dst  = src;
      o_who  = src;
      o_link = NULL_ID;
      o_excl = 1'b0;
      n_head = c_head;
      n_pend = c_pend;
      n_excl = c_excl;
      n_lock = c_lock;
      case (req_kind_e'(kind))
         REQ_READ: if (!c_lock) begin
            upd    = 1'b1;
            n_head = src;
            n_excl = 1'b0;
            if (empty) o_kind = MSG_GRANT;
            else begin
               o_kind = MSG_FWD;
               o_dst  = c_head;
            end
         end
         REQ_WRITE: if (!c_lock) begin
            upd = 1'b1;
            if (empty || (c_head == src && c_excl)) begin
               o_kind = MSG_GRANT;
               o_excl = 1'b1;
               n_head = src;
               n_excl = 1'b1;
            end else begin
               o_kind = MSG_INVAL;
               o_dst  = c_head;
               n_lock = 1'b1;
               n_pend = src;
            end
         end
         REQ_EVICT: if (!c_lock) begin
            if (c_head == src) begin
               upd    = 1'b1;
               o_kind = MSG_EVOK;
               n_head = link;
               n_excl = 1'b0;
            end else if (empty) begin
               o_kind = MSG_EVOK;
            end else begin
               upd    = 1'b1;
               o_kind = MSG_UNLINK;
               o_dst  = c_head;
               o_link = link;
               n_lock = 1'b1;
               n_pend = NULL_ID;
            end
         end
         default: begin
            emit = 1'b0;
            if (c_lock) begin
               upd    = 1'b1;
               n_lock = 1'b0;
               if (c_pend != NULL_ID) begin
                  n_head = c_pend;
                  n_excl = 1'b1;
               end
            end
         end
      endcase
   end
endmodule

// File: rtl/hsl_home_dir.sv
module hsl_home_dir #(
   parameter  int NODES  = 7,
   parameter  int LINES  = 8,
   localparam int NODE_W = $clog2(NODES + 1),
   localparam int LINE_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_kind,
   input  logic [NODE_W-1:0] req_src,
   input  logic [LINE_W-1:0] req_line,
   input  logic [NODE_W-1:0] req_link,
   output logic              msg_valid,
   input  logic              msg_ready,
   output logic [2:0]        msg_kind,
   output logic [NODE_W-1:0] msg_dst,
   output logic [NODE_W-1:0] msg_who,
   output logic [NODE_W-1:0] msg_link,
   output logic [LINE_W-1:0] msg_line,
   output logic              msg_excl
);
   if (LINES < 2 || (1 << LINE_W) != LINES) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (NODES < 1) begin : g_bad_nodes
      $error("NODES must be at least 1");
   end

   logic [NODE_W-1:0] head_a [LINES];
   logic [NODE_W-1:0] pend_a [LINES];
   logic              excl_a [LINES];
   logic              lock_a [LINES];

   logic              acc, emit, upd, n_excl, n_lock, o_excl;
   logic [NODE_W-1:0] n_head, n_pend, o_dst, o_who, o_link;
   logic [2:0]        o_kind;

   assign req_ready = !msg_valid || msg_ready;
   assign acc       = req_valid && req_ready;

   for (genvar i = 0; i < LINES; i++) begin : g_line
      hsl_line_slot #(.NODE_W(NODE_W)) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (acc && upd && (req_line == LINE_W'(i))),
         .nxt_head(n_head),
         .nxt_pend(n_pend),
         .nxt_excl(n_excl),
         .nxt_lock(n_lock),
         .head    (head_a[i]),
         .pend    (pend_a[i]),
         .excl    (excl_a[i]),
         .lock    (lock_a[i])
      );
   end

   hsl_decide #(.NODE_W(NODE_W)) u_decide (
      .kind  (req_kind),
      .src   (req_src),
      .link  (req_link),
      .c_head(head_a[req_line]),
      .c_pend(pend_a[req_line]),
      .c_excl(excl_a[req_line]),
      .c_lock(lock_a[req_line]),
      .emit  (emit),
      .upd   (upd),
      .n_head(n_head),
      .n_pend(n_pend),
      .n_excl(n_excl),
      .n_lock(n_lock),
      .o_kind(o_kind),
      .o_dst (o_dst),
      .o_who (o_who),
      .o_link(o_link),
      .o_excl(o_excl)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         msg_valid <= 1'b0;
         msg_kind  <= '0;
         msg_dst   <= '0;
         msg_who   <= '0;
         msg_link  <= '0;
         msg_line  <= '0;
         msg_excl  <= 1'b0;
      end else if (acc) begin
         msg_valid <= emit;
         msg_kind  <= o_kind;
         msg_dst   <= o_dst;
         msg_who   <= o_who;
         msg_link  <= o_link;
         msg_line  <= req_line;
         msg_excl  <= o_excl;
      end else if (msg_ready) begin
         msg_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/hsl_home_dir_chk.sv
module hsl_home_dir_chk #(
   parameter int NODE_W = 3,
   parameter int LINE_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [1:0]        req_kind,
   input logic [NODE_W-1:0] req_src,
   input logic              msg_valid,
   input logic              msg_ready,
   input logic [2:0]        msg_kind,
   input logic [NODE_W-1:0] msg_dst,
   input logic [NODE_W-1:0] msg_who,
   input logic [NODE_W-1:0] msg_link,
   input logic [LINE_W-1:0] msg_line,
   input logic              msg_excl
);
   logic acc;
   assign acc = req_valid && req_ready;

   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_kind) && $stable(msg_dst)
         && $stable(msg_who) && $stable(msg_link) && $stable(msg_line) && $stable(msg_excl)));

   a_r11_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |-> !req_ready);

   a_r8_ack_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_kind == 2'd3) |=> !msg_valid);

   a_r6_one_reply: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_kind != 2'd3) |=> msg_valid);

   a_r6_reply_target: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && req_kind != 2'd3) |=>
         ((msg_kind == 3'd0 || msg_kind == 3'd4 || msg_kind == 3'd5)
            ? (msg_dst == $past(req_src)) : (msg_who == $past(req_src))));

   a_r2_grant_null_link: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_kind == 3'd0) |-> (msg_link == '1));

   a_r4_excl_only_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_kind != 3'd0) |-> !msg_excl);
endmodule

bind hsl_home_dir hsl_home_dir_chk #(.NODE_W(NODE_W), .LINE_W(LINE_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_valid(req_valid),
   .req_ready(req_ready),
   .req_kind (req_kind),
   .req_src  (req_src),
   .msg_valid(msg_valid),
   .msg_ready(msg_ready),
   .msg_kind (msg_kind),
   .msg_dst  (msg_dst),
   .msg_who  (msg_who),
   .msg_link (msg_link),
   .msg_line (msg_line),
   .msg_excl (msg_excl)
);

// File: tb/test_hsl_home_dir.sv
module test_hsl_home_dir;
   localparam int NW = 3;
   localparam int LW = 2;
   localparam logic [NW-1:0] NUL = 3'd7;
   localparam logic [1:0] RD = 2'd0, WR = 2'd1, EV = 2'd2, AK = 2'd3;
   localparam logic [2:0] K_GR = 3'd0, K_FW = 3'd1, K_IN = 3'd2, K_UL = 3'd3,
                          K_NK = 3'd4, K_EV = 3'd5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, msg_ready = 1'b1;
   logic [1:0] req_kind = '0;
   logic [NW-1:0] req_src = '0, req_link = '0;
   logic [LW-1:0] req_line = '0;
   logic req_ready, msg_valid, msg_excl;
   logic [2:0] msg_kind;
   logic [NW-1:0] msg_dst, msg_who, msg_link;
   logic [LW-1:0] msg_line;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   hsl_home_dir #(.NODES(5), .LINES(4)) i_hsl_home_dir (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_kind(req_kind), .req_src(req_src), .req_line(req_line), .req_link(req_link),
      .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind), .msg_dst(msg_dst),
      .msg_who(msg_who), .msg_link(msg_link), .msg_line(msg_line), .msg_excl(msg_excl));

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic send(input logic [1:0] k, input logic [NW-1:0] s,
                       input logic [LW-1:0] ln, input logic [NW-1:0] lk);
      @(negedge clk);
      req_kind = k; req_src = s; req_line = ln; req_link = lk; req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic expect_msg(input string tag, input logic [2:0] k,
                             input logic [NW-1:0] d, input logic [NW-1:0] w,
                             input logic [NW-1:0] lk, input logic ex,
                             input logic [LW-1:0] ln);
      chk(msg_valid == 1'b1, tag, "msg_valid", int'(msg_valid), 1);
      chk(msg_kind == k, tag, "msg_kind", int'(msg_kind), int'(k));
      chk(msg_dst == d, tag, "msg_dst", int'(msg_dst), int'(d));
      chk(msg_who == w, tag, "msg_who", int'(msg_who), int'(w));
      chk(msg_link == lk, tag, "msg_link", int'(msg_link), int'(lk));
      chk(msg_excl == ex, tag, "msg_excl", int'(msg_excl), int'(ex));
      chk(msg_line == ln, tag, "msg_line", int'(msg_line), int'(ln));
   endtask

   task automatic expect_none(input string tag);
      chk(msg_valid == 1'b0, tag, "msg_valid", int'(msg_valid), 0);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(msg_valid == 1'b0, "R1", "msg_valid", int'(msg_valid), 0);
      chk(req_ready == 1'b1, "R1", "req_ready", int'(req_ready), 1);
      send(RD, 3'd1, 2'd0, NUL);
      expect_msg("R1/R2", K_GR, 3'd1, 3'd1, NUL, 1'b0, 2'd0);
   endtask

   task automatic t_read_chain;
      send(RD, 3'd2, 2'd0, NUL);
      expect_msg("R3", K_FW, 3'd1, 3'd2, NUL, 1'b0, 2'd0);
      send(RD, 3'd3, 2'd0, NUL);
      expect_msg("R3", K_FW, 3'd2, 3'd3, NUL, 1'b0, 2'd0);
   endtask

   task automatic t_write_lock;
      send(WR, 3'd4, 2'd0, NUL);
      expect_msg("R5", K_IN, 3'd3, 3'd4, NUL, 1'b0, 2'd0);
      send(RD, 3'd1, 2'd0, NUL);
      expect_msg("R6", K_NK, 3'd1, 3'd1, NUL, 1'b0, 2'd0);
      send(WR, 3'd2, 2'd0, NUL);
      expect_msg("R6", K_NK, 3'd2, 3'd2, NUL, 1'b0, 2'd0);
      send(EV, 3'd3, 2'd0, NUL);
      expect_msg("R6", K_NK, 3'd3, 3'd3, NUL, 1'b0, 2'd0);
      send(RD, 3'd1, 2'd1, NUL);
      expect_msg("R12", K_GR, 3'd1, 3'd1, NUL, 1'b0, 2'd1);
      send(AK, 3'd0, 2'd2, NUL);
      expect_none("R8");
      send(RD, 3'd2, 2'd2, NUL);
      expect_msg("R8", K_GR, 3'd2, 3'd2, NUL, 1'b0, 2'd2);
      send(AK, 3'd3, 2'd0, NUL);
      expect_none("R7");
      send(WR, 3'd4, 2'd0, NUL);
      expect_msg("R7", K_GR, 3'd4, 3'd4, NUL, 1'b1, 2'd0);
      send(RD, 3'd1, 2'd0, NUL);
      expect_msg("R7", K_FW, 3'd4, 3'd1, NUL, 1'b0, 2'd0);
   endtask

   task automatic t_exclusive;
      send(WR, 3'd2, 2'd3, NUL);
      expect_msg("R4", K_GR, 3'd2, 3'd2, NUL, 1'b1, 2'd3);
      send(WR, 3'd2, 2'd3, NUL);
      expect_msg("R13", K_GR, 3'd2, 3'd2, NUL, 1'b1, 2'd3);
      send(RD, 3'd3, 2'd3, NUL);
      expect_msg("R13", K_FW, 3'd2, 3'd3, NUL, 1'b0, 2'd3);
   endtask

   task automatic t_evict;
      send(RD, 3'd2, 2'd1, NUL);
      expect_msg("R3", K_FW, 3'd1, 3'd2, NUL, 1'b0, 2'd1);
      send(EV, 3'd1, 2'd1, NUL);
      expect_msg("R10", K_UL, 3'd2, 3'd1, NUL, 1'b0, 2'd1);
      send(RD, 3'd3, 2'd1, NUL);
      expect_msg("R10", K_NK, 3'd3, 3'd3, NUL, 1'b0, 2'd1);
      send(AK, 3'd2, 2'd1, NUL);
      expect_none("R10");
      send(RD, 3'd3, 2'd1, NUL);
      expect_msg("R10", K_FW, 3'd2, 3'd3, NUL, 1'b0, 2'd1);
      send(EV, 3'd3, 2'd1, 3'd2);
      expect_msg("R9", K_EV, 3'd3, 3'd3, NUL, 1'b0, 2'd1);
      send(RD, 3'd0, 2'd1, NUL);
      expect_msg("R9", K_FW, 3'd2, 3'd0, NUL, 1'b0, 2'd1);
      send(EV, 3'd0, 2'd1, 3'd2);
      expect_msg("R9", K_EV, 3'd0, 3'd0, NUL, 1'b0, 2'd1);
      send(EV, 3'd2, 2'd1, NUL);
      expect_msg("R9", K_EV, 3'd2, 3'd2, NUL, 1'b0, 2'd1);
      send(RD, 3'd1, 2'd1, NUL);
      expect_msg("R9", K_GR, 3'd1, 3'd1, NUL, 1'b0, 2'd1);
   endtask

   task automatic t_backpressure;
      @(negedge clk);
      msg_ready = 1'b0;
      send(RD, 3'd3, 2'd2, NUL);
      expect_msg("R11", K_FW, 3'd2, 3'd3, NUL, 1'b0, 2'd2);
      req_kind = RD; req_src = 3'd4; req_line = 2'd2; req_valid = 1'b1;
      for (int c = 0; c < 3; c++) begin
         chk(req_ready == 1'b0, "R11", "req_ready", int'(req_ready), 0);
         expect_msg("R11", K_FW, 3'd2, 3'd3, NUL, 1'b0, 2'd2);
         @(negedge clk);
      end
      msg_ready = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      expect_msg("R11", K_FW, 3'd3, 3'd4, NUL, 1'b0, 2'd2);
      @(negedge clk);
      expect_none("R11");
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_read_chain();
      t_write_lock();
      t_exclusive();
      t_evict();
      t_backpressure();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule